// File: doc/BRIEF.md
# Signature-Unlocked Serial Timekeeping Port

This block sits on a byte-wide memory bus in front of a RAM and a 64-bit timekeeping word. Each bus cycle appears as a one-clock strobe with a direction flag, an in-block select, write data and read data. As long as the block is locked, every selected cycle passes straight through to the RAM. While this happens the block watches data bit 0 of selected writes for a fixed 64-bit unlock signature, which is a parameter.

When the full signature has been seen, the next 64 selected cycles form a transfer window and never reach the RAM. A read in the window returns one bit of a snapshot of the current time on data bit 0. A write in the window replaces the matching bit of that snapshot. When the window closes, the block asks the timekeeper to load the word, but only if at least one write took place. It then locks again. Cycles whose select is low have no effect on either phase, so other traffic can be mixed in freely.

Top module: `hidden_reg_port`

## Requirements
- R1: After synchronous active-high reset the block is locked, the signature pointer is at bit 0, there is no lockout, `timeLoad` is low, and `busRdata` equals `ramRdata`.
- R2: While locked, a selected cycle (`cycValid` and `cycSel` high) drives `ramEn` high, with `ramWe` equal to `cycWrite`, `ramWdata` equal to `cycWdata`, and `busRdata` equal to `ramRdata`. This includes the writes that carry the signature.
- R3: The signature is compared on `cycWdata[0]` of selected writes, bit 0 of the `KEY` parameter first. Each matching write advances the pointer, and the match on bit 63 opens the transfer window for the next selected cycle.
- R4: While locked, a selected read sets the pointer back to bit 0 and clears any lockout, so a new attempt begins.
- R5: A selected write whose bit 0 differs from the signature bit at the pointer sets a lockout. Later writes then neither advance the pointer nor unlock until a selected read (R4) occurs.
- R6: The transfer window lasts exactly 64 selected cycles, and `ramEn` stays low for all of them. A read at window cycle i (counting from 0) returns snapshot bit i on `busRdata[0]`, with `busRdata[7:1]` zero.
- R7: The snapshot equals `timeNow` as sampled in the first window cycle. Later changes to `timeNow` do not affect what reads return.
- R8: If the window held at least one write, `timeLoad` pulses for one clock in the cycle after the 64th window cycle. `timeLoadWord` bit i then holds `cycWdata[0]` of window cycle i where that cycle was a write, and snapshot bit i where it was a read. If the window held no writes, there is no pulse.
- R9: After the 64th window cycle the block is locked again, with the pointer at 0 and no lockout, and RAM access resumes.
- R10: A cycle with `cycSel` low, or with `cycValid` low, never drives `ramEn`. It does not change the pointer, the lockout, the window position or the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycValid | input | 1 | One-clock bus cycle strobe |
| cycWrite | input | 1 | Cycle direction, 1 = write |
| cycSel | input | 1 | Cycle targets this memory block |
| cycWdata | input | 8 | Write data; bit 0 carries signature and transfer bits |
| ramRdata | input | 8 | Read data from the RAM |
| timeNow | input | 64 | Current timekeeping word |
| ramEn | output | 1 | RAM cycle enable |
| ramWe | output | 1 | RAM write enable |
| ramWdata | output | 8 | RAM write data |
| busRdata | output | 8 | Read data returned to the bus |
| timeLoad | output | 1 | One-clock request to load `timeLoadWord` |
| timeLoadWord | output | 64 | Word to load into the timekeeper |

## Verification
The hardest state to reach from the ports is the transfer window entered after a long signature run. To get there, 64 correct writes must arrive with no read among them, while unselected cycles are mixed in. Random traffic almost never produces this. The stimulus therefore reads the bench's own model pointer and sends the correct signature bit most of the time, rarely flipping it or issuing a read. Directed runs add the near misses: the last bit wrong, a read just before completion, and a read-only window that must not cause a load.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  typedef struct packed {
    logic capture;     // first window cycle: take snapshot
    logic shift;       // a window cycle is taking place
    logic shiftWrite;  // that window cycle is a write
    logic finish;      // last window cycle and a load is due
  } hrpStrobes_t;
endpackage

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
  import hrp_pkg::*;
#(
  parameter int KEY_LEN = 64,
  parameter logic [KEY_LEN-1:0] KEY = '0,
  parameter int XFER_LEN = 64,
  localparam int PTR_W = $clog2(KEY_LEN),
  localparam int CNT_W = $clog2(XFER_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cycHit,
  input  logic             cycWrite,
  input  logic             keyBitIn,
  output hrpStrobes_t      strb,
  output logic             xferActive,
  output logic             lockout,
  output logic [PTR_W-1:0] ptr,
  output logic [CNT_W-1:0] xcnt
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(KEY_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XFER_LEN - 1);

  logic wroteAny;
  logic keyMatch;
  logic lastCycle;

  assign keyMatch  = (keyBitIn == KEY[ptr]);
  assign lastCycle = (xcnt == CNT_LAST);

  always_comb begin
    strb.capture    = cycHit && xferActive && (xcnt == '0);
    strb.shift      = cycHit && xferActive;
    strb.shiftWrite = cycWrite;
    strb.finish     = cycHit && xferActive && lastCycle && (wroteAny || cycWrite);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      lockout    <= 1'b0;
      xferActive <= 1'b0;
      xcnt       <= '0;
      wroteAny   <= 1'b0;
    end else if (cycHit) begin
      if (!xferActive) begin
        if (!cycWrite) begin
          ptr     <= '0;
          lockout <= 1'b0;
        end else if (!lockout) begin
          if (keyMatch) begin
            if (ptr == PTR_LAST) begin
              xferActive <= 1'b1;
              ptr        <= '0;
              xcnt       <= '0;
              wroteAny   <= 1'b0;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end else begin
            lockout <= 1'b1;
          end
        end
      end else begin
        if (lastCycle) begin
          xferActive <= 1'b0;
          xcnt       <= '0;
          wroteAny   <= 1'b0;
          ptr        <= '0;
          lockout    <= 1'b0;
        end else begin
          xcnt     <= xcnt + 1'b1;
          wroteAny <= wroteAny || cycWrite;
        end
      end
    end
  end
endmodule

// File: rtl/hrp_datapath.sv
module hrp_datapath
  import hrp_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  hrpStrobes_t       strb,
  input  logic              bitIn,
  input  logic [TIME_W-1:0] timeNow,
  output logic              rdBit,
  output logic              timeLoad,
  output logic [TIME_W-1:0] timeLoadWord
);
  logic [TIME_W-1:0] shiftReg;
  logic [TIME_W-1:0] baseWord;
  logic              newTop;

  // bit i of the snapshot sits at position 0 in window cycle i
  assign baseWord = strb.capture ? timeNow : shiftReg;
  assign rdBit    = baseWord[0];
  assign newTop   = strb.shiftWrite ? bitIn : baseWord[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      timeLoad <= 1'b0;
    end else begin
      timeLoad <= strb.finish;
      if (strb.shift) shiftReg <= {newTop, baseWord[TIME_W-1:1]};
    end
  end

  assign timeLoadWord = shiftReg;
endmodule

// File: rtl/hidden_reg_port.sv
module hidden_reg_port
  import hrp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TIME_W = 64,
  parameter int KEY_LEN = 64,
  parameter logic [KEY_LEN-1:0] KEY = 64'hA5C3_1E7F_0B96_D248,
  localparam int PTR_W = $clog2(KEY_LEN),
  localparam int CNT_W = $clog2(TIME_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycValid,
  input  logic              cycWrite,
  input  logic              cycSel,
  input  logic [DATA_W-1:0] cycWdata,
  input  logic [DATA_W-1:0] ramRdata,
  input  logic [TIME_W-1:0] timeNow,
  output logic              ramEn,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              timeLoad,
  output logic [TIME_W-1:0] timeLoadWord
);
  hrpStrobes_t      strb;
  logic             cycHit;
  logic             xferActive;
  logic             lockout;
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] xcnt;
  logic             rdBit;

  assign cycHit = cycValid && cycSel;

  hrp_ctrl #(
    .KEY_LEN(KEY_LEN), .KEY(KEY), .XFER_LEN(TIME_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .cycHit(cycHit), .cycWrite(cycWrite),
    .keyBitIn(cycWdata[0]), .strb(strb), .xferActive(xferActive),
    .lockout(lockout), .ptr(ptr), .xcnt(xcnt)
  );

  hrp_datapath #(.TIME_W(TIME_W)) uData (
    .clk(clk), .rst(rst), .strb(strb), .bitIn(cycWdata[0]),
    .timeNow(timeNow), .rdBit(rdBit), .timeLoad(timeLoad),
    .timeLoadWord(timeLoadWord)
  );

  assign ramEn    = cycHit && !xferActive;
  assign ramWe    = ramEn && cycWrite;
  assign ramWdata = cycWdata;
  assign busRdata = xferActive ? {{(DATA_W-1){1'b0}}, rdBit} : ramRdata;
endmodule

// File: rtl/hrp_checker.sv
module hrp_checker #(
  parameter int PTR_W = 6,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cycValid,
  input logic             cycWrite,
  input logic             cycSel,
  input logic             ramEn,
  input logic             timeLoad,
  input logic             xferActive,
  input logic             lockout,
  input logic [PTR_W-1:0] ptr,
  input logic [CNT_W-1:0] xcnt
);
  assert_ram_gated_R2: assert property (@(posedge clk) disable iff (rst)
    ramEn |-> (cycValid && cycSel));

  assert_ram_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    xferActive |-> !ramEn);

  assert_read_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (cycValid && cycSel && !cycWrite && !xferActive) |=> (ptr == '0 && !lockout));

  assert_lockout_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (lockout && cycValid && cycSel && cycWrite && !xferActive) |=>
      (lockout && $stable(ptr) && !xferActive));

  assert_foreign_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (!(cycValid && cycSel)) |=>
      ($stable(ptr) && $stable(xcnt) && $stable(xferActive) && $stable(lockout)));

  assert_load_single_R8: assert property (@(posedge clk) disable iff (rst)
    timeLoad |=> !timeLoad);

  assert_relock_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(xferActive) |-> (ptr == '0 && !lockout));
endmodule

bind hidden_reg_port hrp_checker #(.PTR_W(PTR_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rst(rst), .cycValid(cycValid), .cycWrite(cycWrite),
  .cycSel(cycSel), .ramEn(ramEn), .timeLoad(timeLoad),
  .xferActive(xferActive), .lockout(lockout), .ptr(ptr), .xcnt(xcnt)
);

// File: tb/tb_hidden_reg_port.sv
module tb_hidden_reg_port;
  localparam logic [63:0] KEY = 64'hA5C3_1E7F_0B96_D248;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cycValid = 1'b0, cycWrite = 1'b0, cycSel = 1'b0;
  logic [7:0]  cycWdata = '0, ramRdata = '0;
  logic [63:0] timeNow = '0;
  logic        ramEn, ramWe, timeLoad;
  logic [7:0]  ramWdata, busRdata;
  logic [63:0] timeLoadWord;

  int checks = 0, failures = 0;

  // bench model
  int          mPtr = 0, mCnt = 0;
  bit          mMiss = 0, mXfer = 0, mWrote = 0, pendLoad = 0;
  logic [63:0] mSnap = '0, mWord = '0, pendWord = '0;

  hidden_reg_port #(.KEY(KEY)) dut (
    .clk(clk), .rst(rst), .cycValid(cycValid), .cycWrite(cycWrite),
    .cycSel(cycSel), .cycWdata(cycWdata), .ramRdata(ramRdata),
    .timeNow(timeNow), .ramEn(ramEn), .ramWe(ramWe), .ramWdata(ramWdata),
    .busRdata(busRdata), .timeLoad(timeLoad), .timeLoadWord(timeLoadWord)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit w, input bit s, input logic [7:0] d);
    bit hit;
    bit snapBit;
    @(negedge clk);
    // R8: load pulse from the previous cycle
    check(timeLoad == pendLoad, "R8 load pulse", 64'(timeLoad), 64'(pendLoad));
    if (pendLoad) check(timeLoadWord == pendWord, "R8 load word", timeLoadWord, pendWord);
    pendLoad = 0;
    cycValid = v; cycWrite = w; cycSel = s; cycWdata = d;
    ramRdata = 8'($urandom);
    timeNow  = {$urandom, $urandom};
    hit = v && s;
    #1;
    if (!hit) begin
      check(ramEn == 1'b0, "R10 no ramEn", 64'(ramEn), 64'(0));
    end else if (!mXfer) begin
      check(ramEn == 1'b1 && ramWe == w && ramWdata == d, "R2 ram access",
            {ramEn, ramWe, ramWdata}, {1'b1, w, d});
      if (!w) check(busRdata == ramRdata, "R2 ram read", 64'(busRdata), 64'(ramRdata));
    end else begin
      check(ramEn == 1'b0, "R6 ram blocked", 64'(ramEn), 64'(0));
      if (mCnt == 0) mSnap = timeNow;
      snapBit = mSnap[mCnt];
      if (!w) check(busRdata == {7'b0, snapBit}, "R6 R7 window read",
                    64'(busRdata), 64'({7'b0, snapBit}));
    end
    @(posedge clk);
    if (hit) begin
      if (!mXfer) begin
        if (!w) begin mPtr = 0; mMiss = 0; end
        else if (!mMiss) begin
          if (d[0] == KEY[mPtr]) begin
            if (mPtr == 63) begin mXfer = 1; mPtr = 0; mCnt = 0; mWrote = 0; end
            else mPtr++;
          end else mMiss = 1;
        end
      end else begin
        mWord[mCnt] = w ? d[0] : mSnap[mCnt];
        if (w) mWrote = 1;
        if (mCnt == 63) begin
          pendLoad = mWrote; pendWord = mWord;
          mXfer = 0; mCnt = 0; mPtr = 0; mMiss = 0; mWrote = 0;
        end else mCnt++;
      end
    end
  endtask

  task automatic sendKey(input int upTo, input bit flipLast);
    for (int i = 0; i < upTo; i++) begin
      if (i % 7 == 3) cyc(1, 1, 0, 8'($urandom));  // R10 foreign cycle mixed in
      cyc(1, 1, 1, {7'($urandom), (flipLast && i == upTo - 1) ? ~KEY[i] : KEY[i]});
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    check(timeLoad == 0, "R1 timeLoad", 64'(timeLoad), 0);
    check(ramEn == 0 && busRdata == ramRdata, "R1 outputs", {ramEn, busRdata}, {1'b0, ramRdata});

    // R3 R7 full key, read-only window: no load expected
    sendKey(64, 0);
    for (int i = 0; i < 64; i++) begin
      if (i % 5 == 0) cyc(1, 0, 0, 8'h00);
      cyc(1, 0, 1, 8'h00);
    end
    cyc(0, 0, 0, 8'h00);
    check(mXfer == 0, "R9 model relocked", 64'(mXfer), 0);

    // R8 mixed window with writes
    sendKey(64, 0);
    for (int i = 0; i < 64; i++) cyc(1, (i % 3) != 1, 1, 8'($urandom));
    cyc(1, 0, 1, 8'h00);  // R9 ram access resumes
    cyc(0, 0, 0, 8'h00);

    // R5 near miss: last key bit wrong, then more writes must not unlock
    cyc(1, 0, 1, 8'h00);
    sendKey(64, 1);
    for (int i = 0; i < 70; i++) cyc(1, 1, 1, {7'd0, KEY[i % 64]});
    cyc(1, 1, 1, 8'h00);

    // R4 read just before completion restarts
    cyc(1, 0, 1, 8'h00);
    sendKey(63, 0);
    cyc(1, 0, 1, 8'h00);
    cyc(1, 1, 1, {7'd0, KEY[63]});
    cyc(1, 1, 1, 8'h00);  // still RAM access expected
    sendKey(64, 0);
    for (int i = 0; i < 64; i++) cyc(1, 1, 1, 8'($urandom));
    cyc(0, 0, 0, 8'h00);

    // random phase steered toward the key
    for (int n = 0; n < 6000; n++) begin
      bit v, s, w;
      logic [7:0] d;
      v = ($urandom % 8) != 0;
      s = ($urandom % 6) != 0;
      d = 8'($urandom);
      if (!mXfer) begin
        w = ($urandom % 60) != 0;
        d[0] = (($urandom % 90) == 0) ? ~KEY[mPtr] : KEY[mPtr];
      end else w = $urandom % 2;
      cyc(v, w, s, d);
    end
    cyc(0, 0, 0, 8'h00);
    cyc(0, 0, 0, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule